// File: doc/BRIEF.md
# Multi-Channel Latency Deskew Aligner

This block takes sample streams from several converter channels. Each stream reaches the back end with its own fixed latency. The block lines the streams up so that samples with the same index leave on the same clock cycle. Every channel's total latency is loaded from outside, for example from a figure reported by the device that produced the stream. The block pads each faster channel with extra delay so that it matches the slowest one. The padding is held in a small elastic buffer for each lane. Once all lanes hold enough data, one sample from each lane is released per cycle. A per-slot selection map can rearrange the lanes at the output.

A one-cycle re-align pulse does three things: it empties every buffer, loads the latency values and the slot map into working registers, and restarts filling. If any buffer is pushed while full or read while empty, alignment is lost. The block then raises a sticky error and holds the output invalid until the next re-align.

Top module: `lane_deskew`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `valid_o`, `err_o` and `data_o` are all zero. After reset the slot map is the identity and every latency is zero.
- R2: The alignment target is the largest loaded latency. Lane c is given an extra delay equal to the target minus its own latency. Every output slot in a valid cycle therefore carries the same sample index.
- R3: The first release happens on the first cycle in which every lane c holds at least (target − latency_c + 1) entries. With streams that start after their latencies, measured from the cycle after re-align, the first valid output appears after the edge that ends cycle target+1, and it carries sample index 0.
- R4: After the first release, every lane gives up one entry on every cycle. `valid_o` stays high on every following cycle until a re-align or a fault, so a continuous stream of N samples gives exactly N consecutive valid cycles.
- R5: Output slot s carries the lane whose index is stored in map field s, at `map_i[s*CH_W +: CH_W]`. Lane c data sits at `data_i[c*DATA_W +: DATA_W]`, slot s data at `data_o[s*DATA_W +: DATA_W]`, and lane c latency at `lat_i[c*LAT_W +: LAT_W]`.
- R6: Changes on `lat_i` and `map_i` have no effect until a re-align. A re-align empties all buffers, drops any sample presented in that same cycle, and clears `valid_o` on the next cycle.
- R7: A sample offered to a lane that holds 2^LAT_W entries in a cycle with no release sets `err_o`.
- R8: A release attempted while any lane is empty sets `err_o`. A single missing sample on a zero-delay lane in steady flow sets `err_o` one cycle after the gap.
- R9: `err_o` stays set and `valid_o` stays low, with the buffers frozen, until a re-align clears the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| realign_i | input | 1 | One-cycle pulse: flush the buffers, load latencies and map |
| vld_i | input | NUM_CH | Per-lane sample valid |
| data_i | input | NUM_CH*DATA_W | Per-lane sample data, flat |
| lat_i | input | NUM_CH*LAT_W | Per-lane total latency, flat |
| map_i | input | NUM_CH*CH_W | Per-slot source lane index, flat |
| valid_o | output | 1 | Aligned output valid |
| data_o | output | NUM_CH*DATA_W | Aligned, reordered samples |
| err_o | output | 1 | Sticky alignment-loss flag |

## Verification
Each lane carries its own index and a running sample count. A skewed latency set with the identity map shows whether padding brings equal indices together, and the cycle of the first release shows whether the fill threshold is exact. A second latency set with a permuted map separates lane selection from delay. Changing the inputs in mid-stream shows that the working registers are isolated from the ports. A silent slow lane drives the other lanes to overflow at a known cycle, and a one-cycle gap on one lane in steady flow exposes underflow and the sticky error that follows.

// File: rtl/deskew_pkg.sv
`timescale 1ns/1ps
package deskew_pkg;
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } align_state_e;
endpackage

// File: rtl/lane_fifo.sv
`timescale 1ns/1ps
module lane_fifo #(
  parameter int DATA_W = 16,
  parameter int AW     = 6,
  localparam int CNT_W = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] mem_q [2**AW];
  logic [AW-1:0]     wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + AW'(1);
      if (pop_i)  rd_q <= rd_q + AW'(1);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/align_ctrl.sv
`timescale 1ns/1ps
module align_ctrl
  import deskew_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int LAT_W  = 6,
  localparam int CNT_W = LAT_W + 1,
  localparam int DEPTH = 1 << LAT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    realign_i,
  input  logic [NUM_CH*LAT_W-1:0] lat_i,
  input  logic [NUM_CH*CNT_W-1:0] cnt_i,
  input  logic [NUM_CH-1:0]       vld_i,
  output logic [NUM_CH-1:0]       push_o,
  output logic                    pop_o,
  output logic                    flush_o,
  output logic                    err_o
);
  align_state_e     state_q, state_d;
  logic [LAT_W-1:0] tgt;
  logic [NUM_CH-1:0] ready_v, empty_v, full_v;
  logic try_pop, fault;

  // alignment target: slowest lane
  always_comb begin
    tgt = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (lat_i[c*LAT_W +: LAT_W] > tgt) tgt = lat_i[c*LAT_W +: LAT_W];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic [CNT_W-1:0] need, cnt;
    assign cnt        = cnt_i[c*CNT_W +: CNT_W];
    assign need       = CNT_W'(tgt) - CNT_W'(lat_i[c*LAT_W +: LAT_W]) + CNT_W'(1);
    assign ready_v[c] = cnt >= need;
    assign empty_v[c] = cnt == '0;
    assign full_v[c]  = cnt == CNT_W'(DEPTH);
  end

  assign try_pop = (state_q == ST_RUN) || (state_q == ST_FILL && &ready_v);
  assign fault   = (state_q != ST_FAULT) &&
                   ((try_pop && |empty_v) ||
                    |(vld_i & full_v & ~{NUM_CH{try_pop}}));

  assign pop_o   = try_pop && !fault && !realign_i;
  assign push_o  = vld_i & {NUM_CH{(state_q != ST_FAULT) && !fault && !realign_i}};
  assign flush_o = realign_i;
  assign err_o   = state_q == ST_FAULT;

  always_comb begin
    state_d = state_q;
    if (realign_i)  state_d = ST_FILL;
    else if (fault) state_d = ST_FAULT;
    else if (pop_o) state_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FILL;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/slot_xbar.sv
`timescale 1ns/1ps
module slot_xbar #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 16,
  parameter int CH_W   = 3
) (
  input  logic [NUM_CH*DATA_W-1:0] lane_i,
  input  logic [NUM_CH*CH_W-1:0]   sel_i,
  output logic [NUM_CH*DATA_W-1:0] slot_o
);
  logic [DATA_W-1:0] lanes [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_unpack
    assign lanes[c] = lane_i[c*DATA_W +: DATA_W];
  end

  for (genvar s = 0; s < NUM_CH; s++) begin : g_slot
    assign slot_o[s*DATA_W +: DATA_W] = lanes[sel_i[s*CH_W +: CH_W]];
  end
endmodule

// File: rtl/lane_deskew.sv
`timescale 1ns/1ps
module lane_deskew #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 16,
  parameter int LAT_W  = 6,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W = LAT_W + 1,
  localparam int DEPTH = 1 << LAT_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     realign_i,
  input  logic [NUM_CH-1:0]        vld_i,
  input  logic [NUM_CH*DATA_W-1:0] data_i,
  input  logic [NUM_CH*LAT_W-1:0]  lat_i,
  input  logic [NUM_CH*CH_W-1:0]   map_i,
  output logic                     valid_o,
  output logic [NUM_CH*DATA_W-1:0] data_o,
  output logic                     err_o
);
  logic [NUM_CH*LAT_W-1:0]  lat_q;
  logic [NUM_CH*CH_W-1:0]   map_q;
  logic [NUM_CH*CNT_W-1:0]  cnt_flat;
  logic [NUM_CH*DATA_W-1:0] head_flat, slot_flat;
  logic [NUM_CH-1:0]        push_en;
  logic                     pop_en, flush;

  // working copies, loaded only by re-align
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lat_q <= '0;
    else if (realign_i) lat_q <= lat_i;
  end

  for (genvar s = 0; s < NUM_CH; s++) begin : g_map
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        map_q[s*CH_W +: CH_W] <= CH_W'(s);
      else if (realign_i) map_q[s*CH_W +: CH_W] <= map_i[s*CH_W +: CH_W];
    end
  end

  align_ctrl #(.NUM_CH(NUM_CH), .LAT_W(LAT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .realign_i (realign_i),
    .lat_i     (lat_q),
    .cnt_i     (cnt_flat),
    .vld_i     (vld_i),
    .push_o    (push_en),
    .pop_o     (pop_en),
    .flush_o   (flush),
    .err_o     (err_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_fifo
    lane_fifo #(.DATA_W(DATA_W), .AW(LAT_W)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (flush),
      .push_i  (push_en[c]),
      .pop_i   (pop_en),
      .data_i  (data_i[c*DATA_W +: DATA_W]),
      .head_o  (head_flat[c*DATA_W +: DATA_W]),
      .count_o (cnt_flat[c*CNT_W +: CNT_W])
    );
  end

  slot_xbar #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_xbar (
    .lane_i (head_flat),
    .sel_i  (map_q),
    .slot_o (slot_flat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= pop_en;
      if (pop_en) data_o <= slot_flat;
    end
  end
endmodule

// File: rtl/lane_deskew_chk.sv
`timescale 1ns/1ps
module lane_deskew_chk #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 7,
  parameter int DEPTH  = 64
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    realign_i,
  input logic [NUM_CH-1:0]       vld_i,
  input logic                    valid_o,
  input logic                    err_o,
  input logic                    pop_i,
  input logic [NUM_CH*CNT_W-1:0] cnt_i
);
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !realign_i |=> err_o); // R9

  AST_ERR_MUTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o); // R9

  AST_REALIGN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_i |=> !err_o && !valid_o); // R6

  AST_LOCKSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !realign_i |=> valid_o || err_o); // R4

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_i[c] && cnt_i[c*CNT_W +: CNT_W] == CNT_W'(DEPTH) && !pop_i && !realign_i
      |=> err_o); // R7

    AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o && !err_o && cnt_i[c*CNT_W +: CNT_W] == '0 && !realign_i
      |=> err_o); // R8
  end
endmodule

bind lane_deskew lane_deskew_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .DEPTH  (DEPTH)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .realign_i (realign_i),
  .vld_i     (vld_i),
  .valid_o   (valid_o),
  .err_o     (err_o),
  .pop_i     (pop_en),
  .cnt_i     (cnt_flat)
);

// File: tb/lane_deskew_tb_top.sv
`timescale 1ns/1ps
module lane_deskew_tb_top;
  localparam int NCH = 8;
  localparam int DW  = 16;
  localparam int LW  = 6;
  localparam int CW  = 3;
  localparam int DEP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic realign = 1'b0;
  logic [NCH-1:0]    vld = '0;
  logic [NCH*DW-1:0] din = '0;
  logic [NCH*LW-1:0] lat = '0;
  logic [NCH*CW-1:0] map = '0;
  logic              valid_o, err_o;
  logic [NCH*DW-1:0] dout;

  always #5 clk = ~clk;

  lane_deskew #(.NUM_CH(NCH), .DATA_W(DW), .LAT_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .realign_i(realign), .vld_i(vld),
    .data_i(din), .lat_i(lat), .map_i(map),
    .valid_o(valid_o), .data_o(dout), .err_o(err_o)
  );

  int n_vec = 0, n_fail = 0;
  string cur_req = "R1";
  int cur_lat[NCH];
  int exp_map[NCH];

  // behavioural reference
  int  mq[NCH][$];
  int  m_lat[NCH], m_map[NCH], m_data[NCH], m_hd[NCH];
  bit  m_run, m_err, m_valid, m_rdy, m_tp, m_flt;
  int  m_tgt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        mq[c].delete(); m_lat[c] = 0; m_map[c] = c; m_data[c] = 0;
      end
      m_run = 0; m_err = 0; m_valid = 0;
    end else if (realign) begin
      for (int c = 0; c < NCH; c++) begin
        mq[c].delete();
        m_lat[c] = int'(lat[c*LW +: LW]);
        m_map[c] = int'(map[c*CW +: CW]);
      end
      m_run = 0; m_err = 0; m_valid = 0;
    end else if (!m_err) begin
      m_tgt = 0;
      for (int c = 0; c < NCH; c++) if (m_lat[c] > m_tgt) m_tgt = m_lat[c];
      m_rdy = 1;
      for (int c = 0; c < NCH; c++) if (mq[c].size() < m_tgt - m_lat[c] + 1) m_rdy = 0;
      m_tp  = m_run || m_rdy;
      m_flt = 0;
      for (int c = 0; c < NCH; c++) begin
        if (m_tp && mq[c].size() == 0) m_flt = 1;
        if (vld[c] && mq[c].size() == DEP && !m_tp) m_flt = 1;
      end
      if (m_flt) begin
        m_err = 1; m_run = 0; m_valid = 0;
      end else begin
        if (m_tp) begin
          for (int c = 0; c < NCH; c++) m_hd[c] = mq[c].pop_front();
          for (int s = 0; s < NCH; s++) m_data[s] = m_hd[m_map[s]];
        end
        for (int c = 0; c < NCH; c++) if (vld[c]) mq[c].push_back(int'(din[c*DW +: DW]));
        m_run = m_tp; m_valid = m_tp;
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk(cur_req, "valid_o vs model", longint'(valid_o), longint'(m_valid));
    chk(cur_req, "err_o vs model", longint'(err_o), longint'(m_err));
    if (m_valid)
      for (int s = 0; s < NCH; s++)
        chk(cur_req, $sformatf("slot %0d vs model", s), longint'(dout[s*DW +: DW]), longint'(m_data[s]));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic do_realign();
    for (int c = 0; c < NCH; c++) begin
      lat[c*LW +: LW] = LW'(cur_lat[c]);
      map[c*CW +: CW] = CW'(exp_map[c]);
    end
    vld = '0;
    for (int c = 0; c < NCH; c++) din[c*DW +: DW] = 16'hFFFF; // dropped (R6)
    vld = '1;
    realign = 1'b1;
    tick();
    realign = 1'b0;
    vld = '0;
    chk("R6", "valid_o after realign", longint'(valid_o), 0);
    chk("R9", "err_o after realign", longint'(err_o), 0);
  endtask

  task automatic run_stream(input string map_req, input int nsamp, input int silent,
                            input int gap_ch, input int gap_t, input int mid_t,
                            input int ncyc, output int err_t, output int n_valid);
    int lmax = 0;
    bit seen = 0;
    err_t = -1; n_valid = 0;
    for (int c = 0; c < NCH; c++) if (cur_lat[c] > lmax) lmax = cur_lat[c];
    for (int t = 0; t < ncyc; t++) begin
      for (int c = 0; c < NCH; c++) begin
        int  k = t - cur_lat[c];
        bit  v = (k >= 0) && (k < nsamp) && (c != silent) && !(c == gap_ch && t == gap_t);
        vld[c] = v;
        din[c*DW +: DW] = v ? 16'((c << 12) | (k & 12'hFFF)) : 16'h0;
      end
      if (t == mid_t) begin
        for (int c = 0; c < NCH; c++) begin
          lat[c*LW +: LW] = LW'(5);
          map[c*CW +: CW] = CW'(NCH - 1 - c);
        end
      end
      tick();
      if (err_o && err_t < 0) err_t = t;
      if (valid_o) begin
        n_valid++;
        for (int s = 0; s < NCH; s++) begin
          chk(map_req, $sformatf("slot %0d source lane", s),
              longint'(dout[s*DW+12 +: 4]), longint'(exp_map[s]));
          chk("R2", $sformatf("slot %0d index matches slot 0", s),
              longint'(dout[s*DW +: 12]), longint'(dout[11:0]));
        end
        if (!seen) begin
          seen = 1;
          chk("R3", "first release cycle", t, lmax + 1);
          chk("R3", "first released index", longint'(dout[11:0]), 0);
        end
      end
    end
    vld = '0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int et, nv;
    // R1 reset
    repeat (3) @(negedge clk);
    chk("R1", "valid_o in reset", longint'(valid_o), 0);
    chk("R1", "err_o in reset", longint'(err_o), 0);
    chk("R1", "data_o in reset", longint'(dout == '0), 1);
    rst_n = 1'b1;
    tick();
    chk("R1", "valid_o after reset", longint'(valid_o), 0);

    // R2/R3/R4 skewed latencies, identity map; R6 input change mid-stream
    cur_req = "R2";
    cur_lat = '{3, 0, 7, 2, 5, 1, 6, 4};
    for (int c = 0; c < NCH; c++) exp_map[c] = c;
    do_realign();
    run_stream("R6", 60, -1, -1, -1, 25, 80, et, nv);
    chk("R4", "valid run length", nv, 60);

    // R5 permuted map with new latencies
    cur_req = "R5";
    cur_lat = '{10, 2, 0, 15, 4, 9, 1, 7};
    exp_map = '{5, 2, 7, 0, 3, 6, 1, 4};
    do_realign();
    run_stream("R5", 50, -1, -1, -1, -1, 80, et, nv);
    chk("R4", "valid run length permuted", nv, 50);

    // R7 overflow: slow lane silent, others fill to depth
    cur_req = "R7";
    cur_lat = '{63, 0, 0, 0, 0, 0, 0, 0};
    for (int c = 0; c < NCH; c++) exp_map[c] = c;
    do_realign();
    run_stream("R7", 100, 0, -1, -1, -1, 70, et, nv);
    chk("R7", "overflow error cycle", et, 64);
    chk("R7", "no release before overflow", nv, 0);

    // R9 sticky error while inputs keep arriving
    cur_req = "R9";
    vld = '1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R9", "err_o held", longint'(err_o), 1);
      chk("R9", "valid_o held low", longint'(valid_o), 0);
    end
    vld = '0;

    // R8 underflow: one missing sample on zero-delay lanes
    cur_req = "R8";
    cur_lat = '{0, 0, 0, 0, 0, 0, 0, 0};
    do_realign();
    chk("R9", "err_o cleared by realign", longint'(err_o), 0);
    run_stream("R5", 40, -1, 3, 10, -1, 30, et, nv);
    chk("R8", "underflow error cycle", et, 11);
    chk("R8", "valid cycles before underflow", nv, 10);

    summary();
    $finish;
  end
endmodule